// File: doc/BRIEF.md
# Dual-Port Interrupt Status Aggregator

This block gathers interrupt events raised by the logic of two storage ports and folds them into a single host interrupt line. Each port owns a sticky 8-bit event status register and an 8-bit mask register. Above them sit a host status register, a host mask register and a host control register. All five kinds of register are reached through a small register bus that takes one write per cycle and returns read data one cycle after the address is presented.

Events arrive as single-cycle pulses. A pulse sets its status bit, and the bit stays set until software writes a 1 to it. A status bit raises its port's pending summary only when the matching mask bit is 0. The port summaries and a software interrupt source then pass through the host mask into a global summary, which drives the output line unless the global interrupt-off bit is set. A self-clearing soft reset returns every status and mask register to its idle value. It does not touch the control bits.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on a port event input sets the matching port status bit, and the bit stays set until cleared. Port status bit positions are: 0 device removed, 1 device attached, 2 command complete, 3 fatal error, 4 device interrupt, 5 reply queue not empty.
- R2: Writing a port status register clears exactly the bits written as 1. Bits written as 0 keep their value, and writing 0xFF clears every event.
- R3: When an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R4: In a port mask register a 1 blocks the matching event. Only bits 5:0 are stored, bits 7:6 read 0, and the value after reset is 0x3F.
- R5: Port status bit 7 reads 1 exactly when some status bit in 5:0 is set and unmasked. Bit 6 reads 0, and bits 7:6 ignore writes.
- R6: Host status bit 0 and bit 1 mirror the pending summaries of port 0 and port 1 and cannot be written. Host status bit 14 is a software interrupt, set by a pulse on `soft_evt` and cleared by writing 1 to it.
- R7: The host mask stores bits 0, 1 and 14, where a 1 blocks that source, and resets to 0x4003. Host status bit 15 reads 1 exactly when some host source is set and unmasked.
- R8: `irq_out` is host status bit 15 delayed by one register stage, and it is forced to 0 one cycle after host control bit 8 (interrupt off) is set.
- R9: Writing host control with bit 13 set starts a soft reset. Bit 13 then reads 1 for exactly 3 cycles and then 0. Afterwards every status register reads 0, the port masks read 0x3F and the host mask reads 0x4003, while control bit 8 and bit 12 (PHY power-down, driven on `phy_pwrdn`) keep their values.
- R10: The register map is: 0 host control, 1 host status, 2 host mask, 4 and 5 port 0 status and mask, 6 and 7 port 1 status and mask. `bus_rdata` shows the register addressed in the previous cycle, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| port_evt | input | 12 | Event pulses, six per port, port 0 in bits 5:0 |
| soft_evt | input | 1 | Software interrupt pulse |
| irq_out | output | 1 | Host interrupt line |
| phy_pwrdn | output | 1 | PHY power-down control bit |

## Verification
The assertions assume that event inputs are single-cycle pulses and that only one register is written per cycle. The bench keeps to both: it raises each pulse for one cycle and issues bus writes one at a time. The properties about event capture also assume that no soft reset is in progress, so they carry that condition, and the bench starts a soft reset only after the port activity has settled. The bench sweeps every mask value against a derived event pattern on each port, which covers masked, partly masked and unmasked events.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W      = 16;
  localparam int PREG_W     = 8;
  localparam int EVT_W      = 6;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_HSTAT = 1;
  localparam int ADDR_HMASK = 2;
  localparam int ADDR_PBASE = 4;
  localparam int CTL_OFF    = 8;
  localparam int CTL_PWRDN  = 12;
  localparam int CTL_SRST   = 13;
  localparam int HST_SOFT   = 14;
  localparam int HST_GLOB   = 15;
  localparam int PST_PEND   = 7;

  function automatic int port_stat_addr(input int p);
    return ADDR_PBASE + 2 * p;
  endfunction

  function automatic int port_mask_addr(input int p);
    return ADDR_PBASE + 2 * p + 1;
  endfunction
endpackage

// File: rtl/irq_soft_reset.sv
module irq_soft_reset #(
  parameter int RST_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start && cnt_q == '0) begin
      cnt_q <= CNT_W'(RST_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // run-length monitor for the self-clearing window
  logic [7:0] run_len;
  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 8'd1;
    else run_len <= '0;
  end

  AST_SRST_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 8'(RST_CYCLES))); // R9
endmodule

// File: rtl/irq_port_regs.sv
module irq_port_regs #(
  parameter int EVT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr,
  input  logic [EVT_W-1:0] evt,
  input  logic             stat_we,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] stat_q,
  output logic [EVT_W-1:0] mask_q,
  output logic             pending
);
  logic [EVT_W-1:0] clr_bits;

  assign clr_bits = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | evt;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pending = |(stat_q & ~mask_q);

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && (|evt)) |=> ((stat_q & $past(evt)) == $past(evt))); // R1
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && stat_we && (|(evt & wdata))) |=>
      ((stat_q & $past(evt & wdata)) == $past(evt & wdata))); // R3
  AST_NO_SPONT_CLR: assert property (@(posedge clk) disable iff (rst)
    (!soft_clr && !stat_we) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (stat_q == '0 && mask_q == '1)); // R9
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 soft_clr,
  input  logic [NUM_PORTS-1:0] port_pend,
  input  logic                 soft_evt,
  input  logic                 stat_we,
  input  logic                 mask_we,
  input  logic                 ctrl_we,
  input  logic [NUM_PORTS-1:0] wd_ports,
  input  logic                 wd_soft,
  input  logic                 wd_off,
  input  logic                 wd_pwrdn,
  output logic [REG_W-1:0]     host_stat,
  output logic [REG_W-1:0]     host_mask,
  output logic                 irq_off,
  output logic                 phy_pwrdn,
  output logic                 irq_out
);
  logic                 soft_q;
  logic [NUM_PORTS-1:0] pmask_q;
  logic                 smask_q;
  logic                 global_pend;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      soft_q  <= 1'b0;
      pmask_q <= '1;
      smask_q <= 1'b1;
    end else begin
      soft_q <= (soft_q & ~(stat_we & wd_soft)) | soft_evt;
      if (mask_we) begin
        pmask_q <= wd_ports;
        smask_q <= wd_soft;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_off   <= 1'b0;
      phy_pwrdn <= 1'b0;
    end else if (ctrl_we) begin
      irq_off   <= wd_off;
      phy_pwrdn <= wd_pwrdn;
    end
  end

  assign global_pend = (|(port_pend & ~pmask_q)) | (soft_q & ~smask_q);

  always_comb begin
    host_stat = '0;
    host_stat[NUM_PORTS-1:0] = port_pend;
    host_stat[HST_SOFT] = soft_q;
    host_stat[HST_GLOB] = global_pend;
    host_mask = '0;
    host_mask[NUM_PORTS-1:0] = pmask_q;
    host_mask[HST_SOFT] = smask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else irq_out <= global_pend & ~irq_off;
  end

  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    irq_off |=> !irq_out); // R8
  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(host_stat[HST_GLOB])); // R7
  AST_PWRDN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (soft_clr && !ctrl_we) |=> $stable(phy_pwrdn)); // R9
  AST_SOFT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (soft_evt && !soft_clr) |=> host_stat[HST_SOFT]); // R6
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wen,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [REG_W-1:0]           bus_wdata,
  output logic [REG_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*EVT_W-1:0] port_evt,
  input  logic                       soft_evt,
  output logic                       irq_out,
  output logic                       phy_pwrdn
);
  logic                 srst_busy;
  logic                 srst_start;
  logic [NUM_PORTS-1:0] port_pend;
  logic [EVT_W-1:0]     pstat [NUM_PORTS];
  logic [EVT_W-1:0]     pmask [NUM_PORTS];
  logic [REG_W-1:0]     host_stat;
  logic [REG_W-1:0]     host_mask;
  logic                 irq_off;
  logic                 unused_wdata;

  assign unused_wdata = ^{bus_wdata[15], bus_wdata[11:9], bus_wdata[7:6]};

  logic we_ctrl, we_hstat, we_hmask;
  assign we_ctrl  = bus_wen && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign we_hstat = bus_wen && (bus_addr == ADDR_W'(ADDR_HSTAT));
  assign we_hmask = bus_wen && (bus_addr == ADDR_W'(ADDR_HMASK));

  assign srst_start = we_ctrl && bus_wdata[CTL_SRST];

  irq_soft_reset #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk   (clk),
    .rst   (rst),
    .start (srst_start),
    .busy  (srst_busy)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic st_we, mk_we;
    assign st_we = bus_wen && (bus_addr == ADDR_W'(port_stat_addr(p)));
    assign mk_we = bus_wen && (bus_addr == ADDR_W'(port_mask_addr(p)));

    irq_port_regs #(.EVT_W(EVT_W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .soft_clr (srst_busy),
      .evt      (port_evt[p*EVT_W +: EVT_W]),
      .stat_we  (st_we),
      .mask_we  (mk_we),
      .wdata    (bus_wdata[EVT_W-1:0]),
      .stat_q   (pstat[p]),
      .mask_q   (pmask[p]),
      .pending  (port_pend[p])
    );
  end

  irq_host_regs #(.NUM_PORTS(NUM_PORTS)) u_host (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (srst_busy),
    .port_pend (port_pend),
    .soft_evt  (soft_evt),
    .stat_we   (we_hstat),
    .mask_we   (we_hmask),
    .ctrl_we   (we_ctrl),
    .wd_ports  (bus_wdata[NUM_PORTS-1:0]),
    .wd_soft   (bus_wdata[HST_SOFT]),
    .wd_off    (bus_wdata[CTL_OFF]),
    .wd_pwrdn  (bus_wdata[CTL_PWRDN]),
    .host_stat (host_stat),
    .host_mask (host_mask),
    .irq_off   (irq_off),
    .phy_pwrdn (phy_pwrdn),
    .irq_out   (irq_out)
  );

  logic [REG_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_next[CTL_OFF]   = irq_off;
      rd_next[CTL_PWRDN] = phy_pwrdn;
      rd_next[CTL_SRST]  = srst_busy;
    end else if (bus_addr == ADDR_W'(ADDR_HSTAT)) begin
      rd_next = host_stat;
    end else if (bus_addr == ADDR_W'(ADDR_HMASK)) begin
      rd_next = host_mask;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(port_stat_addr(p))) begin
        rd_next = '0;
        rd_next[EVT_W-1:0] = pstat[p];
        rd_next[PST_PEND]  = port_pend[p];
      end else if (bus_addr == ADDR_W'(port_mask_addr(p))) begin
        rd_next = '0;
        rd_next[EVT_W-1:0] = pmask[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else bus_rdata <= rd_next;
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(3)) |=> (bus_rdata == '0)); // R10
  AST_PEND_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    (!srst_busy && !(|port_evt) && !bus_wen) |=>
      ((port_pend & ~$past(port_pend)) == '0)); // R5
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [11:0] port_evt = '0;
  logic        soft_evt = 1'b0;
  logic        irq_out;
  logic        phy_pwrdn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_evt(port_evt),
    .soft_evt(soft_evt), .irq_out(irq_out), .phy_pwrdn(phy_pwrdn)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int p, input logic [5:0] e);
    port_evt = 12'(e) << (p * 6);
    @(negedge clk);
    port_evt = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(4'd0, v);  check("R9 ctrl reset", v, 16'h0000);
    rd(4'd1, v);  check("R6 host stat reset", v, 16'h0000);
    rd(4'd2, v);  check("R7 host mask reset", v, 16'h4003);
    rd(4'd4, v);  check("R1 p0 stat reset", v, 16'h0000);
    rd(4'd5, v);  check("R4 p0 mask reset", v, 16'h003F);
    rd(4'd7, v);  check("R4 p1 mask reset", v, 16'h003F);
    rd(4'd15, v); check("R10 unmapped", v, 16'h0000);
    check("R8 irq reset", 16'(irq_out), 16'h0000);

    // sweep every mask value on each port
    wr(4'd2, 16'h0000);
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 64; m++) begin
        logic [5:0] e;
        logic pend;
        e = 6'((m * 5 + p * 3 + 1) & 63);
        pend = |(e & ~6'(m));
        wr(4'(5 + 2*p), 16'(m) | 16'hFFC0);
        pulse(p, e);
        rd(4'(4 + 2*p), v);
        check("R1 R5 port stat", v, 16'(e) | (16'(pend) << 7));
        check("R8 irq follows", 16'(irq_out), 16'(pend));
        rd(4'd1, v);
        check("R6 R7 host stat", v, (16'(pend) << p) | (16'(pend) << 15));
        rd(4'(5 + 2*p), v);
        check("R4 mask readback", v, 16'(m));
        wr(4'(4 + 2*p), 16'h00FF);
        rd(4'(4 + 2*p), v);
        check("R2 clear all", v, 16'h0000);
      end
      wr(4'(5 + 2*p), 16'h00FF);
    end

    // partial clear and collision
    pulse(0, 6'b000011);
    wr(4'd4, 16'h0001);
    rd(4'd4, v); check("R2 partial clear", v, 16'h0002);
    port_evt = 12'h004;
    wr(4'd4, 16'h0004);
    port_evt = '0;
    rd(4'd4, v); check("R3 event beats clear", v, 16'h0006);
    wr(4'd4, 16'h00FF);

    // host mask blocks port source
    wr(4'd5, 16'h0000);
    wr(4'd2, 16'h0001);
    pulse(0, 6'b100000);
    rd(4'd1, v); check("R7 host mask blocks", v, 16'h0001);
    check("R7 irq blocked", 16'(irq_out), 16'h0000);
    wr(4'd1, 16'h0003);
    rd(4'd1, v); check("R6 port bits read-only", v, 16'h0001);
    wr(4'd4, 16'h00FF);
    wr(4'd5, 16'h00FF);

    // software interrupt
    wr(4'd2, 16'h0000);
    soft_evt = 1'b1; tick(); soft_evt = 1'b0;
    rd(4'd1, v); check("R6 soft set", v, 16'hC000);
    check("R8 irq on soft", 16'(irq_out), 16'h0001);
    wr(4'd0, 16'h0100);
    tick();
    check("R8 irq off gate", 16'(irq_out), 16'h0000);
    rd(4'd1, v); check("R8 status kept while off", v, 16'hC000);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h4000);
    rd(4'd1, v); check("R6 soft clear", v, 16'h0000);
    wr(4'd2, 16'h4000);
    soft_evt = 1'b1; tick(); soft_evt = 1'b0;
    rd(4'd1, v); check("R7 soft masked", v, 16'h4000);
    check("R7 irq masked", 16'(irq_out), 16'h0000);

    // soft reset
    wr(4'd2, 16'h0000);
    wr(4'd5, 16'h0000);
    pulse(0, 6'b010000);
    wr(4'd0, 16'h3100);
    rd(4'd0, v); check("R9 srst cycle1", v, 16'h3100);
    rd(4'd0, v); check("R9 srst cycle2", v, 16'h3100);
    rd(4'd0, v); check("R9 srst cycle3", v, 16'h3100);
    rd(4'd0, v); check("R9 srst self clear", v, 16'h1100);
    check("R9 pwrdn pin", 16'(phy_pwrdn), 16'h0001);
    rd(4'd4, v); check("R9 p0 stat cleared", v, 16'h0000);
    rd(4'd5, v); check("R9 p0 mask idle", v, 16'h003F);
    rd(4'd2, v); check("R9 host mask idle", v, 16'h4003);
    rd(4'd1, v); check("R9 host stat cleared", v, 16'h0000);
    check("R9 irq low", 16'(irq_out), 16'h0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule